// File: doc/BRIEF.md
# Receive Byte Queue with Character Timeout

This block is the receive-side buffer of a 16550-style serial port. A deserializer hands it complete bytes and break events. The block keeps them in a 16-entry first-in first-out queue, or in a single holding register when queueing is switched off. A host reads them one at a time through a read strobe.

The block also reports the line status that the interrupt logic needs. It flags data-ready, overrun and break. It compares the queue level against a programmed threshold. It runs a character-gap timer that measures idle time in bit ticks, and the length of a character comes from the current line format.

The control byte and the line format byte use their usual bit positions, so the register decoder next to this block can pass them straight through.

Top module: `rx_fifo_timeout`

## Requirements
- R1: After reset the level is 0, the block is in holding-register mode, data_ready, overrun, brk_flag, trig_hit and tmo_pend are all 0, and rd_data is 0.
- R2: In queue mode (control bit 0 set), bytes come out in arrival order. rd_data shows the oldest byte, each read strobe removes one byte, and level counts the stored bytes.
- R3: The threshold comes from control bits 7:6: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. In queue mode, trig_hit is data_ready AND level >= threshold. In holding mode, trig_hit equals data_ready.
- R4: In queue mode, a byte that arrives while 16 bytes are stored is discarded. The stored bytes are kept and overrun is set. A status-read strobe clears overrun and brk_flag.
- R5: A character is 1 start bit, plus 5 + fmt[1:0] data bits, plus 1 parity bit when fmt[3] is set, plus 2 stop bits when fmt[2] is set (1 otherwise). The timer restarts on every arriving byte or break and on every read that leaves data behind. After 4 characters' worth of bit ticks with data still stored, it sets tmo_pend.
- R6: Any read strobe clears tmo_pend. A read that leaves the queue empty clears data_ready and brk_flag.
- R7: A control write with bit 1 set empties the queue, clears data_ready, brk_flag and tmo_pend, and stops the timer.
- R8: A control write whose bit 0 differs from the current mode empties the queue as in R7, even when bit 1 is clear.
- R9: A break event stores a zero byte and sets both brk_flag and data_ready.
- R10: In holding mode, each byte replaces the held one, and a byte that arrives while data_ready is set raises overrun. A read clears data_ready.
- R11: A read of an empty queue returns 0 and leaves the level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 1 | A received byte is valid this cycle |
| rx_byte | input | 8 | Received byte |
| brk_stb | input | 1 | A break condition was detected on the line |
| fcr_we | input | 1 | Control write strobe |
| fcr_val | input | 8 | Control byte: bit 0 selects queue mode, bit 1 resets the queue, bits 7:6 set the threshold |
| line_fmt | input | 4 | Line format: bits 1:0 set the data length, bit 2 selects two stop bits, bit 3 enables parity |
| bit_tick | input | 1 | One pulse per serial bit time |
| rd_stb | input | 1 | Host reads the data register |
| lsr_rd | input | 1 | Host reads the status register; clears overrun and break |
| rd_data | output | 8 | Oldest byte, or the held byte; 0 when the queue is empty |
| level | output | 5 | Number of stored bytes |
| data_ready | output | 1 | Data is waiting to be read |
| overrun | output | 1 | A byte was lost |
| brk_flag | output | 1 | A break was received |
| trig_hit | output | 1 | The threshold has been reached |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
The properties assume that a break strobe and a byte strobe never arrive together. They also assume that a read strobe never coincides with a control write, because the block resolves those collisions by a fixed priority that the properties do not model. The stimulus drives one strobe per cycle and applies it at the falling edge. It holds the line format constant while a timeout is being measured, so every expected tick count follows from a single format.

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout #(
  parameter int DEPTH = 16,
  parameter int TMO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_stb,
  input  logic [7:0] rx_byte,
  input  logic brk_stb,
  input  logic fcr_we,
  input  logic [7:0] fcr_val,
  input  logic [3:0] line_fmt,
  input  logic bit_tick,
  input  logic rd_stb,
  input  logic lsr_rd,
  output logic [7:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic data_ready,
  output logic overrun,
  output logic brk_flag,
  output logic trig_hit,
  output logic tmo_pend
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_next, trig_lvl;
  logic fen, armed;
  logic [1:0] tsel;
  logic [7:0] hold, tcnt;
  logic [3:0] fbits;
  logic [7:0] tlimit;
  logic unused_bits;

  assign unused_bits = ^fcr_val[5:2];

  wire flush   = fcr_we && (fcr_val[1] || (fcr_val[0] != fen));
  wire in_stb  = rx_stb | brk_stb;
  wire [7:0] in_byte = brk_stb ? 8'h00 : rx_byte;
  wire full    = cnt == CW'(DEPTH);
  wire empty   = cnt == '0;
  wire do_push = fen && in_stb && !full && !flush;
  wire do_pop  = fen && rd_stb && !empty && !flush;
  wire restart = fen && !flush && (in_stb || (do_pop && cnt_next != '0));

  assign cnt_next = cnt + CW'(do_push) - CW'(do_pop);
  assign fbits  = 4'd7 + {2'b00, line_fmt[1:0]} + {3'b000, line_fmt[3]} + {3'b000, line_fmt[2]};
  assign tlimit = 8'(fbits) * 8'(TMO_CHARS);

  always_comb begin
    case (tsel)
      2'd0: trig_lvl = CW'(1);
      2'd1: trig_lvl = CW'(4);
      2'd2: trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
  end

  assign rd_data  = fen ? (empty ? 8'h00 : mem[rp]) : hold;
  assign level    = cnt;
  assign trig_hit = data_ready && (!fen || cnt >= trig_lvl);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      fen <= 1'b0; tsel <= 2'd0; hold <= 8'h00;
      data_ready <= 1'b0; overrun <= 1'b0; brk_flag <= 1'b0; tmo_pend <= 1'b0;
      armed <= 1'b0; tcnt <= '0;
    end else begin
      if (fcr_we) begin
        fen  <= fcr_val[0];
        tsel <= fcr_val[7:6];
      end
      if (lsr_rd) begin
        overrun  <= 1'b0;
        brk_flag <= 1'b0;
      end
      if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0;
        data_ready <= 1'b0; brk_flag <= 1'b0; tmo_pend <= 1'b0;
        armed <= 1'b0; tcnt <= '0;
      end else if (fen) begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        cnt <= cnt_next;
        if (restart) begin
          armed <= 1'b1;
          tcnt  <= '0;
        end else if (armed && bit_tick) begin
          if (tcnt + 8'd1 == tlimit) begin
            armed <= 1'b0;
            tcnt  <= '0;
            if (cnt_next != '0) tmo_pend <= 1'b1;
          end else begin
            tcnt <= tcnt + 8'd1;
          end
        end
        if (rd_stb) begin
          tmo_pend <= 1'b0;
          if (cnt_next == '0) begin
            data_ready <= 1'b0;
            brk_flag   <= 1'b0;
          end
        end
        if (in_stb) begin
          data_ready <= 1'b1;
          if (full) overrun <= 1'b1;
          if (brk_stb) brk_flag <= 1'b1;
        end
      end else begin
        if (rd_stb) begin
          data_ready <= 1'b0;
          brk_flag   <= 1'b0;
          tmo_pend   <= 1'b0;
        end
        if (in_stb) begin
          hold <= in_byte;
          data_ready <= 1'b1;
          if (rx_stb && !brk_stb && data_ready) overrun <= 1'b1;
          if (brk_stb) brk_flag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_fifo_timeout_chk.sv
module rx_fifo_timeout_chk #(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic rx_stb,
  input logic brk_stb,
  input logic fcr_we,
  input logic [7:0] fcr_val,
  input logic rd_stb,
  input logic fen,
  input logic [7:0] rd_data,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic data_ready,
  input logic overrun,
  input logic brk_flag,
  input logic trig_hit,
  input logic tmo_pend
);
  localparam int CW = $clog2(DEPTH+1);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R2

  AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready); // R3

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && level == CW'(DEPTH) && rx_stb && !brk_stb && !fcr_we && !rd_stb)
    |=> (overrun && level == CW'(DEPTH))); // R4

  AST_TMO_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pend |-> level != '0); // R5

  AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !fcr_we) |=> !tmo_pend); // R6

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fcr_val[1]) |=> (level == '0 && !data_ready && !brk_flag && !tmo_pend)); // R7

  AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_stb && !fcr_we) |=> (data_ready && brk_flag)); // R9

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && level == '0) |-> rd_data == 8'h00); // R11
endmodule

bind rx_fifo_timeout rx_fifo_timeout_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .brk_stb(brk_stb),
  .fcr_we(fcr_we), .fcr_val(fcr_val), .rd_stb(rd_stb), .fen(fen),
  .rd_data(rd_data), .level(level), .data_ready(data_ready),
  .overrun(overrun), .brk_flag(brk_flag), .trig_hit(trig_hit),
  .tmo_pend(tmo_pend)
);

// File: tb/tb_rx_fifo_timeout.sv
`timescale 1ns/1ps
module tb_rx_fifo_timeout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_stb = 1'b0, brk_stb = 1'b0, fcr_we = 1'b0, bit_tick = 1'b0;
  logic rd_stb = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rx_byte = 8'h00, fcr_val = 8'h00;
  logic [3:0] line_fmt = 4'h3;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic data_ready, overrun, brk_flag, trig_hit, tmo_pend;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  rx_fifo_timeout dut (
    .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_byte(rx_byte), .brk_stb(brk_stb),
    .fcr_we(fcr_we), .fcr_val(fcr_val), .line_fmt(line_fmt), .bit_tick(bit_tick),
    .rd_stb(rd_stb), .lsr_rd(lsr_rd), .rd_data(rd_data), .level(level),
    .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag),
    .trig_hit(trig_hit), .tmo_pend(tmo_pend)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_stb = 1'b1; rx_byte = b; @(negedge clk); rx_stb = 1'b0;
  endtask
  task automatic brk();
    brk_stb = 1'b1; @(negedge clk); brk_stb = 1'b0;
  endtask
  task automatic rd(output logic [7:0] b);
    b = rd_data; rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
  endtask
  task automatic fcr(input logic [7:0] v);
    fcr_we = 1'b1; fcr_val = v; @(negedge clk); fcr_we = 1'b0;
  endtask
  task automatic stat();
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
  endtask
  task automatic ticks(input int n);
    bit_tick = 1'b1; repeat (n) @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", level, 0);
    chk("R1 flags", {data_ready, overrun, brk_flag, trig_hit, tmo_pend}, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_holding();
    logic [7:0] b;
    push(8'h41);
    chk("R10 ready", data_ready, 1);
    chk("R3 trig in holding mode", trig_hit, 1);
    chk("R10 data", rd_data, 8'h41);
    push(8'h42);
    chk("R10 overrun", overrun, 1);
    chk("R10 replaced", rd_data, 8'h42);
    rd(b);
    chk("R10 read value", b, 8'h42);
    chk("R10 ready cleared", data_ready, 0);
    stat();
    chk("R4 status read clears overrun", overrun, 0);
  endtask

  task automatic t_order_trigger();
    logic [7:0] b;
    fcr(8'h41);
    chk("R8 mode switch empties", level, 0);
    push(8'hA0); push(8'hA1); push(8'hA2);
    chk("R2 level", level, 3);
    chk("R3 below 4", trig_hit, 0);
    push(8'hA3);
    chk("R3 at 4", trig_hit, 1);
    fcr(8'h81);
    chk("R3 retune keeps data", level, 4);
    chk("R3 below 8", trig_hit, 0);
    for (int i = 0; i < 4; i++) begin
      rd(b);
      chk("R2 order", b, 8'hA0 + i);
    end
    chk("R6 empty clears ready", data_ready, 0);
    chk("R11 empty data", rd_data, 0);
    rd(b);
    chk("R11 empty read", b, 0);
    chk("R11 level stays", level, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] b;
    fcr(8'hC3);
    for (int i = 0; i < 16; i++) push(8'h10 + i);
    chk("R4 full", level, 16);
    chk("R3 at 14", trig_hit, 1);
    push(8'hEE);
    chk("R4 overrun", overrun, 1);
    chk("R4 level kept", level, 16);
    for (int i = 0; i < 16; i++) begin
      rd(b);
      chk("R4 contents kept", b, 8'h10 + i);
    end
    stat();
    chk("R4 clear", overrun, 0);
  endtask

  task automatic t_timeout();
    logic [7:0] b;
    line_fmt = 4'h3;
    fcr(8'h03);
    push(8'h55);
    ticks(39);
    chk("R5 not yet 40", tmo_pend, 0);
    ticks(1);
    chk("R5 at 40 ticks", tmo_pend, 1);
    rd(b);
    chk("R6 read clears tmo", tmo_pend, 0);
    push(8'h01); push(8'h02);
    ticks(39);
    rd(b);
    ticks(39);
    chk("R5 restart on read", tmo_pend, 0);
    ticks(1);
    chk("R5 expiry after read", tmo_pend, 1);
    fcr(8'h03);
    chk("R7 flush tmo", tmo_pend, 0);
    line_fmt = 4'hC;
    push(8'h77);
    ticks(35);
    chk("R5 format 9 bits below 36", tmo_pend, 0);
    ticks(1);
    chk("R5 format 9 bits at 36", tmo_pend, 1);
  endtask

  task automatic t_flush_break();
    logic [7:0] b;
    fcr(8'h03);
    push(8'h11); push(8'h22);
    fcr(8'h03);
    chk("R7 level", level, 0);
    chk("R7 ready", data_ready, 0);
    push(8'h33);
    chk("R7 after flush", rd_data, 8'h33);
    rd(b);
    brk();
    chk("R9 zero stored", {level, rd_data}, {5'd1, 8'h00});
    chk("R9 flags", {brk_flag, data_ready}, 2'b11);
    rd(b);
    chk("R6 break cleared", {brk_flag, data_ready}, 0);
    push(8'h44);
    fcr(8'h00);
    chk("R8 disable empties", {level, data_ready}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_holding();
    t_order_trigger();
    t_overrun();
    t_timeout();
    t_flush_break();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule